// File: doc/BRIEF.md
# Single-Precision Float Classifier with Signaling-NaN Quieting

This unit takes one 32-bit binary floating-point word per valid strobe and, one clock later, reports which of six kinds of value it holds: zero, subnormal, normal, infinity, quiet NaN or signaling NaN. It also produces a result word. That word is the input unchanged unless the input was a signaling NaN. In that case it is the same NaN made quiet, and a sticky invalid-operation flag is raised.

A mode input chooses how the top fraction bit is read. In the modern convention a NaN with that bit set is quiet. In the legacy convention the meaning is reversed. Quieting in legacy mode clears that bit. If the fraction would then become zero, which would turn the NaN into an infinity, the next lower fraction bit is set to keep it a NaN. The flag stays set until the clear input is pulsed. A clear and a new signaling NaN in the same cycle leave the flag cleared.

Top module: `fp_class_quiet`

## Requirements
- R1: Each accepted word produces exactly one set bit in `cls_onehot`. The bit positions are 0 zero, 1 subnormal, 2 normal, 3 infinity, 4 quiet NaN and 5 signaling NaN.
- R2: The class is decided from the exponent field (bits 30:23) and the fraction field (bits 22:0):
  - exponent 0 with fraction 0 is zero;
  - exponent 0 with a nonzero fraction is subnormal;
  - an exponent that is neither 0 nor all ones is normal;
  - an all-ones exponent with fraction 0 is infinity;
  - an all-ones exponent with a nonzero fraction is a NaN.
- R3: A NaN is signaling when `nan2008_mode` XOR fraction bit 22 is 1. So with mode 1 a NaN with bit 22 set is quiet, and with mode 0 a NaN with bit 22 set is signaling.
- R4: With mode 1, quieting a signaling NaN sets fraction bit 22 and leaves all other bits unchanged.
- R5: With mode 0, quieting clears fraction bit 22. If the fraction is then zero, fraction bit 21 is set. All other bits are unchanged.
- R6: A word that is not a signaling NaN appears on `res_word` unmodified. Quieting never changes the sign bit or the exponent.
- R7: An accepted signaling NaN sets `invalid_flag` one cycle later. The flag then stays set through later words of any class until a clear.
- R8: `flag_clr` clears the flag in the following cycle, even when a signaling NaN is accepted in the same cycle. Non-signaling words never set the flag.
- R9: Outputs are registered. `res_valid` is `in_valid` delayed by one cycle. With `in_valid` low, `cls_onehot` and `res_word` hold their values.
- R10: After synchronous reset, `res_valid`, `cls_onehot`, `res_word` and `invalid_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_word | input | 32 | Operand word |
| nan2008_mode | input | 1 | 1: set top fraction bit means quiet; 0: legacy polarity |
| flag_clr | input | 1 | Clears the sticky invalid flag |
| res_valid | output | 1 | Result valid, one cycle after `in_valid` |
| cls_onehot | output | 6 | One-hot class of the accepted word |
| res_word | output | 32 | Quieted or passed-through word |
| invalid_flag | output | 1 | Sticky invalid-operation flag |

## Verification
The bench builds the block with its default field widths: an 8-bit exponent and a 23-bit fraction, which is the only layout the requirements describe. With those widths, biased exponent picks of 0, all ones and random values reach every class. Fractions drawn as zero, top-bit-only or random reach the legacy corner where clearing bit 22 leaves a zero fraction. Directed words cover that corner and the modern-mode quieting. Clear pulses are mixed in at random, some landing on the same cycle as a signaling NaN.

// File: rtl/fpcq_pkg.sv
package fpcq_pkg;

    localparam int NUM_CLS = 6;

    typedef enum logic [2:0] {
        CLS_ZERO   = 3'd0,
        CLS_SUB    = 3'd1,
        CLS_NORM   = 3'd2,
        CLS_INF    = 3'd3,
        CLS_QNAN   = 3'd4,
        CLS_SNAN   = 3'd5
    } cls_idx_e;

    typedef struct packed {
        logic [NUM_CLS-1:0] onehot;
        logic               snan;
    } cls_info_t;

    function automatic logic [NUM_CLS-1:0] cls_bit(input cls_idx_e idx);
        logic [NUM_CLS-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/fpcq_classify.sv
module fpcq_classify
    import fpcq_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic              mode2008,
    output cls_info_t         info
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic exp_ones, exp_zero, frac_zero, is_nan;

    assign exp_f     = word[WORD_W-2 -: EXP_W];
    assign frac_f    = word[FRAC_W-1:0];
    assign exp_ones  = &exp_f;
    assign exp_zero  = ~|exp_f;
    assign frac_zero = ~|frac_f;
    assign is_nan    = exp_ones && !frac_zero;

    always_comb begin
        info.snan = is_nan && (mode2008 ^ frac_f[FRAC_W-1]);
        if (exp_zero)
            info.onehot = frac_zero ? cls_bit(CLS_ZERO) : cls_bit(CLS_SUB);
        else if (!exp_ones)
            info.onehot = cls_bit(CLS_NORM);
        else if (frac_zero)
            info.onehot = cls_bit(CLS_INF);
        else
            info.onehot = info.snan ? cls_bit(CLS_SNAN) : cls_bit(CLS_QNAN);
    end

endmodule

// File: rtl/fpcq_quieter.sv
module fpcq_quieter #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic              mode2008,
    input  logic              is_snan,
    output logic [WORD_W-1:0] word_out
);
    logic [FRAC_W-1:0] frac_new;

    always_comb begin
        frac_new = word_in[FRAC_W-1:0];
        if (mode2008) begin
            frac_new[FRAC_W-1] = 1'b1;
        end else begin
            frac_new[FRAC_W-1] = 1'b0;
            if (frac_new == '0)
                frac_new[FRAC_W-2] = 1'b1;
        end
        word_out = is_snan ? {word_in[WORD_W-1:FRAC_W], frac_new} : word_in;
    end

endmodule

// File: rtl/fpcq_sticky.sv
module fpcq_sticky (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic set,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
    end

    p_clr_wins_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> !flag);
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/fp_class_quiet.sv
module fp_class_quiet
    import fpcq_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              nan2008_mode,
    input  logic              flag_clr,
    output logic              res_valid,
    output logic [NUM_CLS-1:0] cls_onehot,
    output logic [WORD_W-1:0] res_word,
    output logic              invalid_flag
);
    cls_info_t         info;
    logic [WORD_W-1:0] quiet_word;

    fpcq_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
        .word(in_word), .mode2008(nan2008_mode), .info(info)
    );

    fpcq_quieter #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_qt (
        .word_in(in_word), .mode2008(nan2008_mode), .is_snan(info.snan),
        .word_out(quiet_word)
    );

    fpcq_sticky u_flag (
        .clk(clk), .rst(rst), .clr(flag_clr),
        .set(in_valid && info.snan), .flag(invalid_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            cls_onehot <= '0;
            res_word   <= '0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                cls_onehot <= info.onehot;
                res_word   <= quiet_word;
            end
        end
    end

    p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $countones(cls_onehot) == 1);
    p_sign_exp_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_word[WORD_W-1:FRAC_W] == $past(in_word[WORD_W-1:FRAC_W]));
    p_pass_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !info.snan) |=> res_word == $past(in_word));
    p_still_nan_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && info.snan) |=> (&res_word[WORD_W-2:FRAC_W]) && (|res_word[FRAC_W-1:0]));
    p_set_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && info.snan && !flag_clr) |=> invalid_flag);
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(res_word) && $stable(cls_onehot) && !res_valid);

endmodule

// File: tb/fp_class_quiet_tb_top.sv
module fp_class_quiet_tb_top;
    logic clk = 1'b0;
    logic rst, in_valid, nan2008_mode, flag_clr;
    logic [31:0] in_word;
    logic res_valid, invalid_flag;
    logic [5:0] cls_onehot;
    logic [31:0] res_word;

    int n_checks = 0, n_fail = 0;
    bit exp_flag = 1'b0;
    bit done = 1'b0;
    logic [5:0]  last_cls;
    logic [31:0] last_word;

    always #10 clk = ~clk;

    fp_class_quiet dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .nan2008_mode(nan2008_mode), .flag_clr(flag_clr),
        .res_valid(res_valid), .cls_onehot(cls_onehot),
        .res_word(res_word), .invalid_flag(invalid_flag)
    );

    function automatic logic [5:0] ref_cls(input logic [31:0] w, input logic m);
        logic [7:0] e = w[30:23];
        logic [22:0] f = w[22:0];
        if (e == 8'h00) return (f == 0) ? 6'b000001 : 6'b000010;
        if (e != 8'hFF) return 6'b000100;
        if (f == 0)     return 6'b001000;
        return (m ^ f[22]) ? 6'b100000 : 6'b010000;
    endfunction

    function automatic logic [31:0] ref_res(input logic [31:0] w, input logic m);
        logic [31:0] r = w;
        if (ref_cls(w, m) != 6'b100000) return w;
        if (m) r[22] = 1'b1;
        else begin
            r[22] = 1'b0;
            if (r[22:0] == 0) r[21] = 1'b1;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at negedge, result is sampled at the following negedge
    task automatic xact(input logic v, input logic [31:0] w, input logic m, input logic c);
        logic [5:0] ec;
        in_valid = v; in_word = w; nan2008_mode = m; flag_clr = c;
        @(posedge clk);
        @(negedge clk);
        if (c) exp_flag = 1'b0;
        else if (v && ref_cls(w, m) == 6'b100000) exp_flag = 1'b1;
        chk("R9 valid", {31'd0, res_valid}, {31'd0, v});
        if (v) begin
            ec = ref_cls(w, m);
            chk("R1/R2/R3 class", {26'd0, cls_onehot}, {26'd0, ec});
            chk("R4/R5/R6 result", res_word, ref_res(w, m));
            last_cls = ec; last_word = ref_res(w, m);
        end else begin
            chk("R9 hold class", {26'd0, cls_onehot}, {26'd0, last_cls});
            chk("R9 hold word", res_word, last_word);
        end
        chk("R7/R8 flag", {31'd0, invalid_flag}, {31'd0, exp_flag});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        logic [7:0] e;
        logic [22:0] f;
        void'($urandom(32'd1234));
        rst = 1'b1; in_valid = 0; in_word = 0; nan2008_mode = 1; flag_clr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10 valid", {31'd0, res_valid}, 32'd0);
        chk("R10 class", {26'd0, cls_onehot}, 32'd0);
        chk("R10 word", res_word, 32'd0);
        chk("R10 flag", {31'd0, invalid_flag}, 32'd0);
        last_cls = 0; last_word = 0;

        // directed corners
        xact(1, 32'h0000_0000, 1, 0);   // R2 zero
        xact(1, 32'h8000_0001, 1, 0);   // R2 subnormal
        xact(1, 32'h3F80_0000, 1, 0);   // R2 normal
        xact(1, 32'hFF80_0000, 1, 0);   // R2 infinity
        xact(1, 32'h7FC0_0000, 1, 0);   // R3 quiet in mode 1, no flag R8
        xact(1, 32'h7F80_0001, 1, 0);   // R4 -> 7FC00001, flag R7
        xact(1, 32'h3F80_0000, 1, 0);   // R7 sticky
        xact(0, 32'h1234_5678, 0, 0);   // R9 hold
        xact(1, 32'h0000_0000, 0, 1);   // R8 clear
        xact(1, 32'h7FC0_0000, 0, 0);   // R5 legacy -> 7FA00000
        xact(1, 32'hFFC0_0003, 0, 0);   // R5 legacy, keeps low bits, sign R6
        xact(1, 32'h7F80_0001, 0, 0);   // R3 quiet in legacy mode
        xact(1, 32'h7F80_0001, 1, 1);   // R8 clear beats set

        for (int i = 0; i < 600; i++) begin
            case ($urandom % 3)
                0: e = 8'h00;
                1: e = 8'hFF;
                default: e = 8'($urandom);
            endcase
            case ($urandom % 4)
                0: f = 23'd0;
                1: f = 23'h40_0000;
                default: f = 23'($urandom);
            endcase
            w = {1'($urandom), e, f};
            xact(($urandom % 5) != 0, w, 1'($urandom), ($urandom % 8) == 0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule